// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

A five-stage twisted-ring counter that walks through ten legal states. Each state drives one of ten active-high one-hot lines. An active-low carry goes low for the upper half of the count. Two count-control inputs come from outside the clock domain. The block synchronizes both and watches them for edges. One input counts on its rising edge while the other is low. The other input counts on its falling edge while the first is high, so each input acts as a level enable for the other.

An asynchronous active-high master reset forces state 0 at once. One interior stage of the ring has a modified next-state term. This term breaks up stray runs of ones and zeros, so any illegal ring code falls back into the ten-state loop within eleven counts. The carry can feed the rising-edge count input of a following counter. Its rising transition happens only on the wrap from 9 to 0, so chained counters hand over with no gap between decoded lines.

A preload port forces any 5-bit code into the ring so that the recovery can be tested. The raw ring is exported for comparison against a reference model. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `decade_ring_decoder`

## Requirements
- R1: While `rst` is high, `ring_o` is 5'b00000, `dec_o` is 10'b0000000001 and `carry_n_o` is 1.
- R2: A low-to-high change of `count_rise_i` while `count_fall_i` is low advances the count by exactly one. The new state shows on `ring_o` at the third rising clock edge after the input change.
- R3: A high-to-low change of `count_fall_i` while `count_rise_i` is high advances the count by exactly one.
- R4: Any other input activity leaves the state unchanged. This includes a rise of `count_rise_i` while `count_fall_i` is high, and a fall of `count_fall_i` while `count_rise_i` is low.
- R5: In legal state k, `dec_o` equals 1<<k. State k holds the following codes (bit 4 on the left):
  - k = 0..5: the k lowest bits are set.
  - k = 6..9: the (k-5) lowest bits are clear and the rest are set.
- R6: `carry_n_o` is 0 in states 5 to 9 and 1 in states 0 to 4.
- R7: `carry_n_o` rises only on the step from state 9 to state 0.
- R8: Raising `rst` returns the block to state 0 without waiting for a clock edge.
- R9: When both qualifying edges are seen in the same clock cycle, the count advances once.
- R10: After any of the 22 illegal codes is preloaded, `ring_o` holds a legal code within 11 advances.
- R11: A high `preload_en_i` at a clock edge loads `preload_val_i` into the ring. This takes precedence over counting.
- R12: A legal state followed by an advance always gives a legal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous master reset, active high |
| count_rise_i | input | 1 | Count input acting on its rising edge; asynchronous |
| count_fall_i | input | 1 | Count input acting on its falling edge; asynchronous |
| preload_en_i | input | 1 | Test preload strobe |
| preload_val_i | input | 5 | Test preload code |
| dec_o | output | 10 | One-hot decoded state, bit k for state k |
| carry_n_o | output | 1 | Active-low carry, low in states 5 to 9 |
| ring_o | output | 5 | Raw ring contents |

## Verification
The bench checks the following corner cases:
- **Cross-gating of the two inputs.** A design that ignored the enable level would count on a blocked edge, and the scoreboard would see an unexpected change.
- **Both edges in one cycle.** A design that added the two edge terms would skip a state.
- **The 9-to-0 wrap.** A carry tied to the wrong ring bit would rise early, or on the 4-to-5 step.
- **All 22 illegal codes.** Each is preloaded and followed advance by advance. A missing or misplaced correction term leaves the ring cycling through illegal codes forever.
- **Latency.** A synchronizer that is one stage too short or too long moves the update edge, and the latency check catches it.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int unsigned STAGES     = 5;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned FIX_STAGE  = 2;

  // True when q is one of the 2*STAGES twisted-ring codes.
  function automatic logic ring_is_legal(input logic [STAGES-1:0] q);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k <= int'(STAGES); k++)
      if (q == STAGES'((1 << k) - 1)) hit = 1'b1;
    for (int k = 1; k < int'(STAGES); k++)
      if (q == ~STAGES'((1 << k) - 1)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/dec_count_qualify.sv
module dec_count_qualify #(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_in,
  input  logic fall_in,
  output logic step_o
);
  logic [SYNC_DEPTH-1:0] rise_sh, fall_sh;
  logic rise_s, fall_s, rise_prev, fall_prev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rise_sh   <= '0;
      fall_sh   <= '0;
      rise_prev <= 1'b0;
      fall_prev <= 1'b0;
    end else begin
      rise_sh   <= {rise_sh[SYNC_DEPTH-2:0], rise_in};
      fall_sh   <= {fall_sh[SYNC_DEPTH-2:0], fall_in};
      rise_prev <= rise_s;
      fall_prev <= fall_s;
    end
  end

  assign rise_s = rise_sh[SYNC_DEPTH-1];
  assign fall_s = fall_sh[SYNC_DEPTH-1];

  // Each input is gated by the level of the other; an OR merges
  // coincident qualifying edges into a single step (R9).
  always_comb begin
    step_o = (rise_s & ~rise_prev & ~fall_s) |
             (fall_prev & ~fall_s & rise_s);
  end

  a_r2_rise_counts: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_s) && !fall_s |-> step_o);
  a_r3_fall_counts: assert property (@(posedge clk) disable iff (rst)
    $fell(fall_s) && rise_s |-> step_o);
  a_r4_quiet_holds: assert property (@(posedge clk) disable iff (rst)
    !$rose(rise_s) && !$fell(fall_s) |-> !step_o);
  a_r4_blocked_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_s) && fall_s && !$fell(fall_s) |-> !step_o);
endmodule

// File: rtl/dec_johnson_ring.sv
module dec_johnson_ring #(
  parameter int unsigned STAGES    = 5,
  parameter int unsigned FIX_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [STAGES-1:0] load_val_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] q, nxt;

  // Plain twisted shift, except one interior stage only accepts a one
  // when a neighbour agrees, which kills isolated ones.
  always_comb begin
    nxt = {q[STAGES-2:0], ~q[STAGES-1]};
    nxt[FIX_STAGE] = q[FIX_STAGE-1] & (q[FIX_STAGE-2] | q[FIX_STAGE]);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         q <= '0;
    else if (load_i) q <= load_val_i;
    else if (step_i) q <= nxt;
  end

  assign q_o = q;

  a_r4_ring_stable: assert property (@(posedge clk) disable iff (rst)
    !step_i && !load_i |=> $stable(q));
  a_r11_preload: assert property (@(posedge clk) disable iff (rst)
    load_i |=> q == $past(load_val_i));
  a_r12_stays_legal: assert property (@(posedge clk) disable iff (rst)
    step_i && !load_i && decade_pkg::ring_is_legal(q) |=> decade_pkg::ring_is_legal(q));
endmodule

// File: rtl/dec_johnson_decode.sv
module dec_johnson_decode #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned STATES = 2 * STAGES
) (
  input  logic [STAGES-1:0] q_i,
  output logic [STATES-1:0] dec_o,
  output logic              carry_n_o
);
  // Each state is found from two adjacent ring bits.
  for (genvar k = 0; k < STATES; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign dec_o[k] = ~q_i[STAGES-1] & ~q_i[0];
    end else if (k < STAGES) begin : g_fill
      assign dec_o[k] = q_i[k-1] & ~q_i[k];
    end else if (k == STAGES) begin : g_full
      assign dec_o[k] = q_i[STAGES-1] & q_i[0];
    end else begin : g_drain
      assign dec_o[k] = ~q_i[k-STAGES-1] & q_i[k-STAGES];
    end
  end

  assign carry_n_o = ~q_i[STAGES-1];
endmodule

// File: rtl/decade_ring_decoder.sv
module decade_ring_decoder #(
  parameter int unsigned STAGES     = decade_pkg::STAGES,
  parameter int unsigned SYNC_DEPTH = decade_pkg::SYNC_DEPTH,
  parameter int unsigned FIX_STAGE  = decade_pkg::FIX_STAGE,
  localparam int unsigned STATES    = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_rise_i,
  input  logic              count_fall_i,
  input  logic              preload_en_i,
  input  logic [STAGES-1:0] preload_val_i,
  output logic [STATES-1:0] dec_o,
  output logic              carry_n_o,
  output logic [STAGES-1:0] ring_o
);
  logic step;

  dec_count_qualify #(.SYNC_DEPTH(SYNC_DEPTH)) u_qual (
    .clk(clk), .rst(rst), .rise_in(count_rise_i), .fall_in(count_fall_i),
    .step_o(step)
  );

  dec_johnson_ring #(.STAGES(STAGES), .FIX_STAGE(FIX_STAGE)) u_ring (
    .clk(clk), .rst(rst), .step_i(step), .load_i(preload_en_i),
    .load_val_i(preload_val_i), .q_o(ring_o)
  );

  dec_johnson_decode #(.STAGES(STAGES)) u_dec (
    .q_i(ring_o), .dec_o(dec_o), .carry_n_o(carry_n_o)
  );

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    decade_pkg::ring_is_legal(ring_o) |-> $onehot(dec_o));
  a_r6_carry_half: assert property (@(posedge clk) disable iff (rst)
    decade_pkg::ring_is_legal(ring_o) |-> carry_n_o == !(|dec_o[STATES-1:STAGES]));
  a_r7_carry_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_n_o) && !$past(preload_en_i) && decade_pkg::ring_is_legal(ring_o)
      && $past(decade_pkg::ring_is_legal(ring_o)) |-> $past(dec_o[STATES-1]) && dec_o[0]);
endmodule

// File: tb/decade_ring_decoder_tb_top.sv
module decade_ring_decoder_tb_top;
  localparam int N = 5;
  localparam int S = 10;

  logic clk = 1'b0, rst = 1'b1, rise = 1'b0, fall = 1'b0, ld = 1'b0;
  logic [N-1:0] ldv = '0;
  logic [S-1:0] dec;
  logic carry_n;
  logic [N-1:0] ring;

  always #2.5 clk = ~clk;

  decade_ring_decoder dut_i (
    .clk(clk), .rst(rst), .count_rise_i(rise), .count_fall_i(fall),
    .preload_en_i(ld), .preload_val_i(ldv), .dec_o(dec),
    .carry_n_o(carry_n), .ring_o(ring)
  );

  int checks = 0, fails = 0, model_k = 0;
  bit sb_on = 1'b0;
  logic [N-1:0] exp_q[$];
  logic [N-1:0] last_seen = '0;
  logic [N-1:0] mon_e;

  function automatic logic [N-1:0] code_of(int k);
    if (k <= N) return N'((1 << k) - 1);
    return ~N'((1 << (k - N)) - 1);
  endfunction

  function automatic int idx_of(logic [N-1:0] q);
    for (int k = 0; k < S; k++) if (q == code_of(k)) return k;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every ring change must match the next queued item.
  always @(negedge clk) begin
    if (sb_on && ring !== last_seen) begin
      if (exp_q.size() == 0) chk("R4 unexpected step", 32'(ring), 32'(last_seen));
      else begin
        mon_e = exp_q.pop_front();
        chk("R2 step value", 32'(ring), 32'(mon_e));
        chk("R5 decode", 32'(dec), 32'(1) << idx_of(mon_e));
        chk("R6 carry", 32'(carry_n), 32'(idx_of(mon_e) < 5));
      end
    end
    last_seen = ring;
  end

  task automatic push_step();
    model_k = (model_k + 1) % S;
    exp_q.push_back(code_of(model_k));
  endtask

  task automatic rise_pulse();
    @(negedge clk) rise = 1'b1;
    repeat (4) @(negedge clk);
    rise = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fall_pulse();
    @(negedge clk) fall = 1'b0;
    repeat (4) @(negedge clk);
    fall = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(string req);
    repeat (6) @(negedge clk);
    chk(req, 32'(exp_q.size()), 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ring", 32'(ring), 0);
    chk("R1 dec", 32'(dec), 1);
    chk("R1 carry", 32'(carry_n), 1);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
    sb_on = 1'b1;

    // R2 latency: update lands on the third rising edge
    @(negedge clk) rise = 1'b1;
    push_step();
    repeat (2) @(negedge clk);
    chk("R2 latency early", 32'(ring), 0);
    @(negedge clk);
    chk("R2 latency on time", 32'(ring), 32'(code_of(1)));
    rise = 1'b0;
    repeat (4) @(negedge clk);

    // R2/R7 rising-input counting through the wrap
    for (int i = 0; i < 12; i++) begin
      bit at_nine;
      at_nine = (model_k == 9);
      if (at_nine) chk("R7 carry low before wrap", 32'(carry_n), 0);
      push_step();
      rise_pulse();
      if (at_nine) begin
        chk("R7 carry high after wrap", 32'(carry_n), 1);
        chk("R7 state zero after wrap", 32'(dec), 1);
      end
    end
    drain("R2 queue empty");

    // R4: rising edge blocked by high falling input
    @(negedge clk) fall = 1'b1;
    repeat (5) @(negedge clk);
    rise = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 blocked rise", 32'(ring), 32'(code_of(model_k)));

    // R3: falling-input counting with rising input held high
    for (int i = 0; i < 4; i++) begin
      push_step();
      fall_pulse();
    end
    drain("R3 queue empty");
    chk("R3 state", 32'(ring), 32'(code_of(model_k)));

    // R4: falling edge while rising input low
    @(negedge clk) rise = 1'b0;
    repeat (5) @(negedge clk);
    fall = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 blocked fall", 32'(ring), 32'(code_of(model_k)));

    // R9: both qualifying edges together give one step
    @(negedge clk) fall = 1'b1;
    repeat (6) @(negedge clk);
    rise = 1'b1; fall = 1'b0;
    push_step();
    repeat (8) @(negedge clk);
    drain("R9 queue empty");
    chk("R9 single step", 32'(ring), 32'(code_of(model_k)));
    rise = 1'b0;
    repeat (6) @(negedge clk);

    // R8: asynchronous reset, checked before any clock edge
    sb_on = 1'b0;
    @(negedge clk);
    #0.5 rst = 1'b1;
    #1;
    chk("R8 async ring", 32'(ring), 0);
    chk("R8 async dec", 32'(dec), 1);
    chk("R8 async carry", 32'(carry_n), 1);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_k = 0;
    repeat (3) @(negedge clk);

    // R11: legal preload
    @(negedge clk) begin ld = 1'b1; ldv = code_of(7); end
    @(negedge clk) ld = 1'b0;
    chk("R11 preload legal", 32'(ring), 32'(code_of(7)));
    chk("R5 decode after preload", 32'(dec), 32'(1) << 7);

    // R10/R11: every illegal code recovers within 11 advances
    for (int c = 0; c < 32; c++) begin
      if (idx_of(N'(c)) < 0) begin
        int n;
        @(negedge clk) begin ld = 1'b1; ldv = N'(c); end
        @(negedge clk) ld = 1'b0;
        chk("R11 preload illegal", 32'(ring), 32'(c));
        n = 0;
        while (idx_of(ring) < 0 && n < 12) begin
          rise_pulse();
          n++;
        end
        chk("R10 recovered within 11", 32'((n <= 11) && (idx_of(ring) >= 0)), 1);
      end
    end

    finish_up();
  end
endmodule